// File: doc/BRIEF.md
# Buffered Timer Channel Value Register

This block is one channel of a 16-bit timer. It holds a compare or capture value that software reaches through an 8-bit bus as a high byte and a low byte. The counter, the counter-advance strobe, the modulo limit and the clock-source select come from a shared timer core. The channel only watches them. It never drives the counter.

Bus writes to the value bytes land in a write buffer that records which bytes have arrived. The buffered value moves into the active register at a point that depends on the channel mode:

- **Clock source stopped:** the value moves as soon as both bytes are present.
- **Output compare:** the value moves on the next counter advance.
- **Edge-aligned PWM:** the value moves only when the counter steps up to its wrap value.
- **Input capture:** bus writes are dropped.

In input capture mode, the active register also loads the counter on a selected pin edge. In compare mode, a match toggles, clears or sets the pin. In PWM mode, the pin is high while the counter is below the active value. Reads of the value go through a latch, so a high-then-low byte pair always comes from one snapshot.

Top module: `tch_chan`

Bus map: address 0 is control/status, address 1 is the value high byte, address 2 is the value low byte, and address 3 reads as zero.

The control byte has these fields:
- bits [1:0]: mode. 00 is capture, 01 is compare, 10 is PWM, 11 is off.
- bits [3:2]: configuration.
  - In capture: 01 is rising edge, 10 is falling edge, 11 is both edges.
  - In compare: 01 is toggle, 10 is clear, 11 is set.
- bit 7: event flag, read back. Writing 1 to bit 7 clears it.

Reads return data on `bus_rdata_o` one clock after `bus_rd_i`.

## Requirements
- R1: In capture mode (mode 00), bus writes to address 1 or 2 leave the active value unchanged.
- R2: With clock select 00, once both value bytes are buffered, the active value takes the buffered value on the following clock. A single written byte commits nothing.
- R3: In compare mode (01) with clock select not 00, a complete buffered value commits only on a clock where `adv_i` is 1. It then commits at the first such clock.
- R4: In PWM mode (10) with a nonzero modulo, a complete buffered value commits only when `adv_i` is 1 and `cnt_i` equals modulo minus one.
- R5: In PWM mode with modulo 0 (free-running counter), the commit happens when `adv_i` is 1 and `cnt_i` is 0xFFFE. It does not happen at any other count.
- R6: Reading the high byte latches the low byte. The next low-byte read returns the latched byte even if the active value changed, and that read empties the latch. A low-byte read with an empty latch returns the live low byte.
- R7: A control write while `halt_i` is 1 empties the read latch. A control write with `halt_i` at 0 does not.
- R8: A control write discards any partly written buffered value, so a later single byte write does not complete it.
- R9: In capture mode, the selected pin edge loads `cnt_i` into the active value and sets the flag. An unselected edge does neither.
- R10: In compare mode, an advance with `cnt_i` equal to the active value applies the configured action to `pin_o` and sets the flag. `pin_o` changes only on clocks with `adv_i` at 1.
- R11: In PWM mode, each advance sets `pin_o` to 1 when the next count is below the active value and to 0 otherwise. The next count is 0 after `cnt_i` equals the modulo, or 0xFFFF when the modulo is 0; otherwise it is `cnt_i`+1.
- R12: A control write with bit 7 set clears the flag, unless an event sets it on the same clock.
- R13: After reset, the control byte, both value bytes and `pin_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Current timer count |
| adv_i | input | 1 | Counter advances at this clock |
| mod_i | input | 16 | Modulo limit (0 means free-running) |
| clksel_i | input | 2 | Clock source select (00 means stopped) |
| halt_i | input | 1 | Debug halt active |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_addr_i | input | 2 | Bus register address |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data, one clock after the read |
| pin_i | input | 1 | Channel pin input (capture) |
| pin_o | output | 1 | Channel pin output (compare/PWM) |

## Verification
A write buffer that loses track of its byte flags shows up at the next value read after the commit point. The read returns either the old value or a half-new value. A commit rule keyed to the wrong count shows up in the same way within one advance of the count being tested. A stale or wrongly cleared read latch shows up as a wrong low byte on the very next low read, which is one clock after the strobe. Errors in edge selection, match action or PWM threshold show up on `pin_o` or in the flag bit one clock after the offending advance or synchronised pin edge.

// File: rtl/tch_pkg.sv
package tch_pkg;
  typedef enum logic [1:0] {
    MD_CAP = 2'b00,
    MD_CMP = 2'b01,
    MD_PWM = 2'b10,
    MD_OFF = 2'b11
  } tch_mode_e;

  localparam logic [1:0] ADR_CTL = 2'd0;
  localparam logic [1:0] ADR_VHI = 2'd1;
  localparam logic [1:0] ADR_VLO = 2'd2;
endpackage

// File: rtl/tch_wbuf.sv
module tch_wbuf
  import tch_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int VAL_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [BUS_W-1:0] wdata,
  input  logic             flush,
  input  tch_mode_e        mode,
  input  logic [1:0]       clksel,
  input  logic             adv,
  input  logic [VAL_W-1:0] cnt,
  input  logic [VAL_W-1:0] modv,
  output logic [VAL_W-1:0] buf_val,
  output logic             full,
  output logic             commit
);
  localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

  logic got_hi, got_lo;
  logic [VAL_W-1:0] lim;
  logic pre_top;

  // count just below the wrap value
  assign lim     = (modv == '0) ? {VAL_W{1'b1}} : modv;
  assign pre_top = (cnt == (lim - ONE));
  assign full    = got_hi & got_lo;

  always_comb begin
    commit = 1'b0;
    if (full && mode != MD_CAP) begin
      if (clksel == 2'b00)      commit = 1'b1;
      else if (mode == MD_PWM)  commit = adv & pre_top;
      else                      commit = adv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      got_hi  <= 1'b0;
      got_lo  <= 1'b0;
      buf_val <= '0;
    end else begin
      if (commit) begin
        got_hi <= 1'b0;
        got_lo <= 1'b0;
      end
      if (mode != MD_CAP) begin
        if (wr_hi) begin
          buf_val[VAL_W-1:BUS_W] <= wdata;
          got_hi <= 1'b1;
        end
        if (wr_lo) begin
          buf_val[BUS_W-1:0] <= wdata;
          got_lo <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tch_evt.sv
module tch_evt
  import tch_pkg::*;
#(
  parameter int VAL_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  tch_mode_e        mode,
  input  logic [1:0]       cfg,
  input  logic             adv,
  input  logic [VAL_W-1:0] cnt,
  input  logic [VAL_W-1:0] modv,
  input  logic [VAL_W-1:0] val,
  input  logic             pin_i,
  output logic             pin_o,
  output logic             cap_evt,
  output logic             hit_evt
);
  localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

  logic [SYNC_N:0] sh;
  logic rise, fall;
  logic [VAL_W-1:0] lim, nxt;
  logic wrap, cmp_hit;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_N-1:0], pin_i};
  end

  assign rise = sh[SYNC_N-1] & ~sh[SYNC_N];
  assign fall = ~sh[SYNC_N-1] & sh[SYNC_N];

  assign cap_evt = (mode == MD_CAP) &&
                   ((cfg[0] && rise) || (cfg[1] && fall));

  assign lim     = (modv == '0) ? {VAL_W{1'b1}} : modv;
  assign wrap    = (cnt == lim);
  assign nxt     = wrap ? '0 : cnt + ONE;
  assign cmp_hit = adv && (cnt == val);

  always_comb begin
    hit_evt = 1'b0;
    if (mode == MD_CMP) hit_evt = cmp_hit;
    else if (mode == MD_PWM) hit_evt = adv && (nxt == val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o <= 1'b0;
    end else if (adv) begin
      if (mode == MD_PWM) begin
        pin_o <= (nxt < val);
      end else if (mode == MD_CMP && cmp_hit) begin
        case (cfg)
          2'b01:   pin_o <= ~pin_o;
          2'b10:   pin_o <= 1'b0;
          2'b11:   pin_o <= 1'b1;
          default: pin_o <= pin_o;
        endcase
      end
    end
  end
endmodule

// File: rtl/tch_rdlatch.sv
module tch_rdlatch
  import tch_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int VAL_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic [1:0]       addr,
  input  logic             halt,
  input  logic             ctl_wr,
  input  logic [VAL_W-1:0] val,
  input  logic [BUS_W-1:0] ctl_byte,
  output logic [BUS_W-1:0] rdata
);
  logic             lat_v;
  logic [BUS_W-1:0] lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_v <= 1'b0;
      lat   <= '0;
      rdata <= '0;
    end else begin
      if (ctl_wr && halt) lat_v <= 1'b0;
      if (rd) begin
        case (addr)
          ADR_CTL: rdata <= ctl_byte;
          ADR_VHI: begin
            rdata <= val[VAL_W-1:BUS_W];
            lat   <= val[BUS_W-1:0];
            lat_v <= 1'b1;
          end
          ADR_VLO: begin
            rdata <= lat_v ? lat : val[BUS_W-1:0];
            lat_v <= 1'b0;
          end
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tch_chan.sv
module tch_chan
  import tch_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int SYNC_N = 2,
  localparam int VAL_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VAL_W-1:0] cnt_i,
  input  logic             adv_i,
  input  logic [VAL_W-1:0] mod_i,
  input  logic [1:0]       clksel_i,
  input  logic             halt_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  input  logic             pin_i,
  output logic             pin_o
);
  tch_mode_e        mode_q;
  logic [1:0]       cfg_q;
  logic             flag_q;
  logic [VAL_W-1:0] val_q;
  logic [VAL_W-1:0] buf_val;
  logic             buf_full, commit;
  logic             cap_evt, hit_evt;
  logic             ctl_wr, wr_hi, wr_lo;
  logic [BUS_W-1:0] ctl_byte;

  assign ctl_wr   = bus_wr_i && bus_addr_i == ADR_CTL;
  assign wr_hi    = bus_wr_i && bus_addr_i == ADR_VHI;
  assign wr_lo    = bus_wr_i && bus_addr_i == ADR_VLO;
  assign ctl_byte = {flag_q, {(BUS_W-5){1'b0}}, cfg_q, mode_q};

  tch_wbuf #(.BUS_W(BUS_W)) u_wbuf (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wdata(bus_wdata_i), .flush(ctl_wr), .mode(mode_q),
    .clksel(clksel_i), .adv(adv_i), .cnt(cnt_i), .modv(mod_i),
    .buf_val(buf_val), .full(buf_full), .commit(commit)
  );

  tch_evt #(.VAL_W(VAL_W), .SYNC_N(SYNC_N)) u_evt (
    .clk(clk), .rst(rst), .mode(mode_q), .cfg(cfg_q), .adv(adv_i),
    .cnt(cnt_i), .modv(mod_i), .val(val_q), .pin_i(pin_i),
    .pin_o(pin_o), .cap_evt(cap_evt), .hit_evt(hit_evt)
  );

  tch_rdlatch #(.BUS_W(BUS_W)) u_rdl (
    .clk(clk), .rst(rst), .rd(bus_rd_i), .addr(bus_addr_i),
    .halt(halt_i), .ctl_wr(ctl_wr), .val(val_q),
    .ctl_byte(ctl_byte), .rdata(bus_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_CAP;
      cfg_q  <= '0;
      flag_q <= 1'b0;
      val_q  <= '0;
    end else begin
      if (ctl_wr) begin
        mode_q <= tch_mode_e'(bus_wdata_i[1:0]);
        cfg_q  <= bus_wdata_i[3:2];
        if (bus_wdata_i[BUS_W-1]) flag_q <= 1'b0;
      end
      if (cap_evt || hit_evt) flag_q <= 1'b1;
      if (cap_evt)     val_q <= cnt_i;
      else if (commit) val_q <= buf_val;
    end
  end
endmodule

// File: rtl/tch_chan_chk.sv
module tch_chan_chk
  import tch_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input tch_mode_e        mode_q,
  input logic [1:0]       clksel_i,
  input logic             adv_i,
  input logic [VAL_W-1:0] val_q,
  input logic [VAL_W-1:0] buf_val,
  input logic             buf_full,
  input logic             cap_evt,
  input logic             hit_evt,
  input logic             ctl_wr,
  input logic             clr_bit,
  input logic             flag_q,
  input logic             pin_o
);
  AST_CAP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_CAP && !cap_evt) |=> $stable(val_q)); // R1

  AST_STOPPED_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MD_CAP && clksel_i == 2'b00 && buf_full) |=> (val_q == $past(buf_val))); // R2

  AST_CMP_WAITS_ADV: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_CMP && clksel_i != 2'b00 && !adv_i) |=> $stable(val_q)); // R3

  AST_PWM_WAITS_ADV: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_PWM && clksel_i != 2'b00 && !adv_i) |=> $stable(val_q)); // R4

  AST_PIN_ON_ADV: assert property (@(posedge clk) disable iff (rst)
    (!adv_i) |=> $stable(pin_o)); // R10

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && clr_bit && !cap_evt && !hit_evt) |=> !flag_q); // R12
endmodule

bind tch_chan tch_chan_chk #(.VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .clksel_i(clksel_i),
  .adv_i(adv_i), .val_q(val_q), .buf_val(buf_val), .buf_full(buf_full),
  .cap_evt(cap_evt), .hit_evt(hit_evt), .ctl_wr(ctl_wr),
  .clr_bit(bus_wdata_i[BUS_W-1]), .flag_q(flag_q), .pin_o(pin_o)
);

// File: tb/sim_tch_chan.sv
`timescale 1ns/1ps
module sim_tch_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt_i = '0;
  logic        adv_i = 1'b0;
  logic [15:0] mod_i = '0;
  logic [1:0]  clksel_i = 2'b00;
  logic        halt_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        pin_i = 1'b0;
  logic        pin_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic rd_q = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  tch_chan u0 (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .adv_i(adv_i), .mod_i(mod_i),
    .clksel_i(clksel_i), .halt_i(halt_i), .bus_wr_i(bus_wr_i),
    .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .pin_i(pin_i), .pin_o(pin_o)
  );

  // monitor: pops expected read data when the read result is present
  always @(posedge clk) rd_q <= bus_rd_i;
  always @(negedge clk) begin
    if (rd_q) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      nchk++;
      if (bus_rdata_o !== e) begin
        nerr++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, bus_rdata_o, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    tick(1);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd_i = 1'b1; bus_addr_i = a;
    tick(1);
    bus_rd_i = 1'b0;
  endtask

  task automatic rdval(input logic [15:0] e, input string t);
    rd(2'd1, e[15:8], t);
    rd(2'd2, e[7:0], t);
  endtask

  task automatic pulse(input logic [15:0] c);
    cnt_i = c; adv_i = 1'b1;
    tick(1);
    adv_i = 1'b0;
  endtask

  task automatic chk_pin(input logic e, input string t);
    nchk++;
    if (pin_o !== e) begin
      nerr++;
      $display("FAIL %s: pin_o=%0b expected=%0b", t, pin_o, e);
    end
  endtask

  task automatic pin_edge(input logic v);
    pin_i = v;
    tick(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic p0;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R13 reset state
    chk_pin(1'b0, "R13");
    rd(2'd0, 8'h00, "R13");
    rdval(16'h0000, "R13");

    // R1 capture mode ignores value writes
    wr(2'd1, 8'hAA); wr(2'd2, 8'h55); tick(2);
    rdval(16'h0000, "R1");

    // R2 stopped clock: commit once both bytes present
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h12); tick(2);
    rdval(16'h0000, "R2");
    wr(2'd2, 8'h34); tick(1);
    rdval(16'h1234, "R2");

    // R3 compare: wait for advance
    clksel_i = 2'b01;
    wr(2'd1, 8'h56); wr(2'd2, 8'h78); tick(3);
    rdval(16'h1234, "R3");
    pulse(16'd100); tick(1);
    rdval(16'h5678, "R3");

    // R8 control write discards a partial buffer
    wr(2'd1, 8'h9A); wr(2'd0, 8'h01); wr(2'd2, 8'hBC);
    pulse(16'd100); tick(1);
    rdval(16'h5678, "R8");

    // R4 PWM commit at modulo-1
    wr(2'd0, 8'h02); mod_i = 16'd20;
    wr(2'd1, 8'h00); wr(2'd2, 8'h0A);
    pulse(16'd5); tick(1);
    rdval(16'h5678, "R4");
    pulse(16'd19); tick(1);
    rdval(16'h000A, "R4");

    // R5 free-running PWM commit at 0xFFFE
    mod_i = 16'd0;
    wr(2'd1, 8'h00); wr(2'd2, 8'h06);
    pulse(16'd19); tick(1);
    rdval(16'h000A, "R5");
    pulse(16'hFFFE); tick(1);
    rdval(16'h0006, "R5");

    // R11 PWM pin over one period (modulo 9, value 6)
    mod_i = 16'd9;
    for (int i = 0; i < 11; i++) begin
      int c;
      int n;
      c = (i == 0) ? 9 : i - 1;
      n = (c == 9) ? 0 : c + 1;
      pulse(16'(c));
      chk_pin(n < 6, "R11");
    end

    // R12 flag set by PWM match, cleared by write
    rd(2'd0, 8'h82, "R12");
    wr(2'd0, 8'h82);
    rd(2'd0, 8'h02, "R12");

    // R10 compare actions
    wr(2'd0, 8'h05);
    p0 = pin_o;
    pulse(16'd6);
    chk_pin(~p0, "R10");
    rd(2'd0, 8'h85, "R10");
    wr(2'd0, 8'h89);
    pulse(16'd6);
    chk_pin(1'b0, "R10");
    wr(2'd0, 8'h0D);
    pulse(16'd7);
    chk_pin(1'b0, "R10");
    pulse(16'd6);
    chk_pin(1'b1, "R10");
    rd(2'd0, 8'h8D, "R10");

    // R9 capture on selected edges only
    wr(2'd0, 8'h84);
    cnt_i = 16'h4321;
    pin_edge(1'b1);
    rdval(16'h4321, "R9");
    rd(2'd0, 8'h84, "R9");
    wr(2'd0, 8'h84);
    cnt_i = 16'h1111;
    pin_edge(1'b0);
    rdval(16'h4321, "R9");
    rd(2'd0, 8'h04, "R9");
    wr(2'd0, 8'h08);
    cnt_i = 16'h2222;
    pin_edge(1'b1);
    rdval(16'h4321, "R9");
    pin_edge(1'b0);
    rdval(16'h2222, "R9");

    // R6 coherent read latch
    rd(2'd1, 8'h22, "R6");
    cnt_i = 16'h3333;
    pin_edge(1'b1); pin_edge(1'b0);
    rd(2'd2, 8'h22, "R6");
    rd(2'd2, 8'h33, "R6");

    // R7 halt control write clears the latch, normal one does not
    rd(2'd1, 8'h33, "R7");
    cnt_i = 16'h4444;
    pin_edge(1'b1); pin_edge(1'b0);
    halt_i = 1'b1; wr(2'd0, 8'h08); halt_i = 1'b0;
    rd(2'd2, 8'h44, "R7");
    rd(2'd1, 8'h44, "R7");
    cnt_i = 16'h5555;
    pin_edge(1'b1); pin_edge(1'b0);
    wr(2'd0, 8'h08);
    rd(2'd2, 8'h44, "R7");

    tick(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule